// File: doc/BRIEF.md
# Hardware Page Table Walker

This block services translation buffer misses entirely in hardware, so software is never trapped on a miss. A base register holds the physical address where the running process's single-level page table starts. Loading a new value into it switches address spaces. On a miss the walker scales the virtual page number by the entry size and adds it to the base. It reads the 32-bit entry over a valid/ready memory port and checks whether the mapping exists.

For a present mapping the walker always marks the entry as referenced. It also marks it as modified when the miss came from a store. If either bit changed, the updated word goes back to memory before the walker delivers the frame number, the protection field and the modified flag to the translation buffer. An absent mapping produces a one-cycle page-fault pulse that carries the faulting page number, and no fill. Only one miss is handled at a time, and a busy flag covers the whole walk.

Top module: `pt_walker`

## Requirements
- R1: While reset is held and right after it, `busy` is 0, `miss_ready` is 1, and `mem_req_valid`, `fill_valid` and `fault_valid` are 0.
- R2: The read request of a walk carries `mem_req_write`=0 and the address base + (vpn × 4), where base is the base register value when the miss is accepted.
- R3: A memory request stays asserted with a stable address, write flag and write data until `mem_req_ready` is seen, and any number of cycles may pass before the response arrives.
- R4: An entry whose valid bit (bit 22) is 0 raises `fault_valid` for exactly one cycle with `fault_vpn` equal to the missed page. No fill and no write-back happen.
- R5: For a valid entry, the write-back word equals the fetched word with the referenced bit (bit 23) set, plus the modified bit (bit 24) when `miss_write` was 1. All other bits are unchanged.
- R6: A write-back is issued only when R5 changed the word. Otherwise the walk goes straight to the fill.
- R7: A fill pulses `fill_valid` for one cycle with `fill_vpn`, `fill_frame` = entry bits 19:0, `fill_prot` = bits 21:20 and `fill_dirty` = the updated bit 24.
- R8: `miss_ready` is 1 exactly when the walker is idle. `busy` rises on the cycle after a miss is accepted, stays 1 up to and including the fill or fault cycle, and is 0 on the cycle after that.
- R9: A base write while idle takes effect for the next accepted miss. A base write during a walk does not affect that walk and is applied once the walker is idle. If several such writes arrive during one walk, the last one wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_wr_en | input | 1 | Load the page table base register |
| base_wr_data | input | PA_W | New page table base address |
| miss_valid | input | 1 | Translation buffer miss request |
| miss_ready | output | 1 | Walker can accept a miss |
| miss_vpn | input | VPN_W | Virtual page number that missed |
| miss_write | input | 1 | The missing access is a store |
| busy | output | 1 | Walk in progress |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write-back, 0 = entry read |
| mem_req_addr | output | PA_W | Entry physical address |
| mem_req_wdata | output | PTE_W | Updated entry for write-back |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_ready | output | 1 | Walker waits for a response |
| mem_rsp_rdata | input | PTE_W | Entry read data |
| fill_valid | output | 1 | Fill pulse to the translation buffer |
| fill_vpn | output | VPN_W | Page being filled |
| fill_frame | output | FRAME_W | Physical frame number |
| fill_prot | output | 2 | Protection field |
| fill_dirty | output | 1 | Modified bit after update |
| fault_valid | output | 1 | Page fault pulse |
| fault_vpn | output | VPN_W | Faulting virtual page number |

## Verification
The bench uses the default widths: a 20-bit page number, a 20-bit frame, 32-bit physical addresses and 32-bit entries. With these values the top page number 0xFFFFF is reachable, so the scaled offset 0x3FFFFC must carry into the upper address bits without truncation. The field positions that decide write-back versus skip (bits 22, 23 and 24) sit right above the frame. Two widely separated table bases let the bench tell from the read address alone whether a deferred base write leaked into a walk that was already running.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RD_REQ  = 3'd1,
    ST_RD_WAIT = 3'd2,
    ST_UPDATE  = 3'd3,
    ST_FAULT   = 3'd4,
    ST_WR_REQ  = 3'd5,
    ST_WR_WAIT = 3'd6,
    ST_FILL    = 3'd7
  } walk_state_e;

endpackage

// File: rtl/ptw_base_reg.sv
module ptw_base_reg #(
  parameter int PA_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [PA_W-1:0] wr_data,
  input  logic            walk_idle,
  output logic [PA_W-1:0] base_q
);

  logic            pend_q, pend_d;
  logic [PA_W-1:0] pend_data_q, pend_data_d;
  logic [PA_W-1:0] base_d;
  logic            base_en, pend_en;

  always_comb begin
    base_d      = base_q;
    base_en     = 1'b0;
    pend_d      = pend_q;
    pend_data_d = pend_data_q;
    pend_en     = 1'b0;
    if (walk_idle) begin
      if (wr_en) begin
        base_d  = wr_data;
        base_en = 1'b1;
      end else if (pend_q) begin
        base_d  = pend_data_q;
        base_en = 1'b1;
      end
      pend_d  = 1'b0;
      pend_en = pend_q;
    end else if (wr_en) begin
      pend_d      = 1'b1;
      pend_data_d = wr_data;
      pend_en     = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q      <= '0;
      pend_q      <= 1'b0;
      pend_data_q <= '0;
    end else begin
      if (base_en) base_q <= base_d;
      if (pend_en) begin
        pend_q      <= pend_d;
        pend_data_q <= pend_data_d;
      end
    end
  end

  // R9: the base seen by a running walk never moves
  a_r9_base_frozen_in_walk: assert property (@(posedge clk) disable iff (!rst_n)
    !walk_idle |=> $stable(base_q));

endmodule

// File: rtl/ptw_entry_update.sv
module ptw_entry_update #(
  parameter int PTE_W   = 32,
  parameter int FRAME_W = 20
) (
  input  logic [PTE_W-1:0] entry_in,
  input  logic             is_store,
  output logic [PTE_W-1:0] entry_out,
  output logic             changed
);

  localparam int REF_BIT = FRAME_W + 3;
  localparam int MOD_BIT = FRAME_W + 4;

  always_comb begin
    entry_out          = entry_in;
    entry_out[REF_BIT] = 1'b1;
    if (is_store) entry_out[MOD_BIT] = 1'b1;
    changed = (entry_out != entry_in);
  end

endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
#(
  parameter int VPN_W   = 20,
  parameter int FRAME_W = 20,
  parameter int PA_W    = 32,
  parameter int PTE_W   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PA_W-1:0]    base_q,
  output logic               walk_idle,
  input  logic               miss_valid,
  output logic               miss_ready,
  input  logic [VPN_W-1:0]   miss_vpn,
  input  logic               miss_write,
  output logic               busy,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic               mem_req_write,
  output logic [PA_W-1:0]    mem_req_addr,
  output logic [PTE_W-1:0]   mem_req_wdata,
  input  logic               mem_rsp_valid,
  output logic               mem_rsp_ready,
  input  logic [PTE_W-1:0]   mem_rsp_rdata,
  output logic               fill_valid,
  output logic [FRAME_W-1:0] fill_frame,
  output logic [1:0]         fill_prot,
  output logic               fill_dirty,
  output logic               fault_valid,
  output logic [VPN_W-1:0]   walk_vpn
);

  localparam int ENTRY_SHIFT = $clog2(PTE_W / 8);
  localparam int OFF_W       = VPN_W + ENTRY_SHIFT;
  localparam int PROT_LSB    = FRAME_W;
  localparam int VALID_BIT   = FRAME_W + 2;
  localparam int REF_BIT     = FRAME_W + 3;
  localparam int MOD_BIT     = FRAME_W + 4;

  walk_state_e        state_q, state_d;
  logic [VPN_W-1:0]   vpn_q;
  logic               store_q;
  logic [PTE_W-1:0]   entry_q, entry_d;
  logic               entry_en, accept;
  logic [PTE_W-1:0]   entry_upd;
  logic               entry_chg;
  logic [PA_W-1:0]    offset;

  ptw_entry_update #(
    .PTE_W  (PTE_W),
    .FRAME_W(FRAME_W)
  ) u_update (
    .entry_in (entry_q),
    .is_store (store_q),
    .entry_out(entry_upd),
    .changed  (entry_chg)
  );

  assign accept = (state_q == ST_IDLE) && miss_valid;

  always_comb begin
    state_d  = state_q;
    entry_d  = entry_q;
    entry_en = 1'b0;
    unique case (state_q)
      ST_IDLE:    if (miss_valid) state_d = ST_RD_REQ;
      ST_RD_REQ:  if (mem_req_ready) state_d = ST_RD_WAIT;
      ST_RD_WAIT: begin
        if (mem_rsp_valid) begin
          entry_d  = mem_rsp_rdata;
          entry_en = 1'b1;
          state_d  = mem_rsp_rdata[VALID_BIT] ? ST_UPDATE : ST_FAULT;
        end
      end
      ST_UPDATE: begin
        entry_d  = entry_upd;
        entry_en = 1'b1;
        state_d  = entry_chg ? ST_WR_REQ : ST_FILL;
      end
      ST_FAULT:   state_d = ST_IDLE;
      ST_WR_REQ:  if (mem_req_ready) state_d = ST_WR_WAIT;
      ST_WR_WAIT: if (mem_rsp_valid) state_d = ST_FILL;
      ST_FILL:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      vpn_q   <= '0;
      store_q <= 1'b0;
      entry_q <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        vpn_q   <= miss_vpn;
        store_q <= miss_write;
      end
      if (entry_en) entry_q <= entry_d;
    end
  end

  generate
    if (PA_W > OFF_W) begin : g_pad
      assign offset = {{(PA_W - OFF_W){1'b0}}, vpn_q, {ENTRY_SHIFT{1'b0}}};
    end else begin : g_trunc
      logic [OFF_W-1:0] off_full;
      assign off_full = {vpn_q, {ENTRY_SHIFT{1'b0}}};
      assign offset   = off_full[PA_W-1:0];
    end
  endgenerate

  assign walk_idle     = (state_q == ST_IDLE);
  assign miss_ready    = walk_idle;
  assign busy          = !walk_idle;
  assign mem_req_valid = (state_q == ST_RD_REQ) || (state_q == ST_WR_REQ);
  assign mem_req_write = (state_q == ST_WR_REQ);
  assign mem_req_addr  = base_q + offset;
  assign mem_req_wdata = entry_q;
  assign mem_rsp_ready = (state_q == ST_RD_WAIT) || (state_q == ST_WR_WAIT);
  assign fill_valid    = (state_q == ST_FILL);
  assign fault_valid   = (state_q == ST_FAULT);
  assign fill_frame    = entry_q[FRAME_W-1:0];
  assign fill_prot     = entry_q[PROT_LSB+1:PROT_LSB];
  assign fill_dirty    = entry_q[MOD_BIT];
  assign walk_vpn      = vpn_q;

  // R3: a pending request holds still until accepted
  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_wdata));
  // R4: fault is a single-cycle pulse and never coincides with a fill
  a_r4_fault_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |=> !fault_valid && !fill_valid);
  // R5: every write-back carries the referenced bit
  a_r5_wb_ref_set: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_write |-> mem_req_wdata[REF_BIT]);
  // R7: fill is a single-cycle pulse
  a_r7_fill_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> !fill_valid);
  // R8: an accepted miss makes the walker busy on the next cycle
  a_r8_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid && miss_ready |=> busy && !miss_ready);
  // R8: the end of a walk returns to idle
  a_r8_end_idle: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid || fault_valid |=> miss_ready);

endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VPN_W   = 20,
  parameter int FRAME_W = 20,
  parameter int PA_W    = 32,
  parameter int PTE_W   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               base_wr_en,
  input  logic [PA_W-1:0]    base_wr_data,
  input  logic               miss_valid,
  output logic               miss_ready,
  input  logic [VPN_W-1:0]   miss_vpn,
  input  logic               miss_write,
  output logic               busy,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic               mem_req_write,
  output logic [PA_W-1:0]    mem_req_addr,
  output logic [PTE_W-1:0]   mem_req_wdata,
  input  logic               mem_rsp_valid,
  output logic               mem_rsp_ready,
  input  logic [PTE_W-1:0]   mem_rsp_rdata,
  output logic               fill_valid,
  output logic [VPN_W-1:0]   fill_vpn,
  output logic [FRAME_W-1:0] fill_frame,
  output logic [1:0]         fill_prot,
  output logic               fill_dirty,
  output logic               fault_valid,
  output logic [VPN_W-1:0]   fault_vpn
);

  logic            rst_meta_q, rst_sync_q;
  logic [PA_W-1:0] base_q;
  logic            walk_idle;
  logic [VPN_W-1:0] walk_vpn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  ptw_base_reg #(.PA_W(PA_W)) u_base (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .wr_en    (base_wr_en),
    .wr_data  (base_wr_data),
    .walk_idle(walk_idle),
    .base_q   (base_q)
  );

  ptw_ctrl #(
    .VPN_W  (VPN_W),
    .FRAME_W(FRAME_W),
    .PA_W   (PA_W),
    .PTE_W  (PTE_W)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_sync_q),
    .base_q       (base_q),
    .walk_idle    (walk_idle),
    .miss_valid   (miss_valid),
    .miss_ready   (miss_ready),
    .miss_vpn     (miss_vpn),
    .miss_write   (miss_write),
    .busy         (busy),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write),
    .mem_req_addr (mem_req_addr),
    .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_ready(mem_rsp_ready),
    .mem_rsp_rdata(mem_rsp_rdata),
    .fill_valid   (fill_valid),
    .fill_frame   (fill_frame),
    .fill_prot    (fill_prot),
    .fill_dirty   (fill_dirty),
    .fault_valid  (fault_valid),
    .walk_vpn     (walk_vpn)
  );

  assign fill_vpn  = walk_vpn;
  assign fault_vpn = walk_vpn;

endmodule

// File: tb/pt_walker_tb.sv
module pt_walker_tb;

  localparam logic [31:0] BASE_A = 32'h0010_0000;
  localparam logic [31:0] BASE_B = 32'h0080_0000;
  localparam logic [31:0] BASE_C = 32'h0200_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_wr_en = 1'b0;
  logic [31:0] base_wr_data = '0;
  logic        miss_valid = 1'b0;
  logic        miss_ready;
  logic [19:0] miss_vpn = '0;
  logic        miss_write = 1'b0;
  logic        busy;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic        mem_req_write;
  logic [31:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic        mem_rsp_ready;
  logic [31:0] mem_rsp_rdata = '0;
  logic        fill_valid;
  logic [19:0] fill_vpn;
  logic [19:0] fill_frame;
  logic [1:0]  fill_prot;
  logic        fill_dirty;
  logic        fault_valid;
  logic [19:0] fault_vpn;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [31:0] mem [logic [31:0]];
  int          n_rd, n_wr;
  logic [31:0] rd_addr, wr_addr, wr_data;
  logic [31:0] cur_base = '0;

  always #2 clk = ~clk;

  pt_walker u_dut (.*);

  function automatic logic [31:0] rd_mem(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  function automatic logic [31:0] exp_update(input logic [31:0] e, input logic st);
    logic [31:0] r;
    r = e | 32'h0080_0000;
    if (st) r = r | 32'h0100_0000;
    return r;
  endfunction

  function automatic logic [31:0] mk_entry(input logic valid);
    logic [31:0] e;
    e = $urandom & 32'h01BF_FFFF;
    e[22] = valid;
    return e;
  endfunction

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory responder: random accept delay and response latency
  initial begin
    logic [31:0] a, wd;
    logic        w;
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        repeat ($urandom % 3) @(negedge clk);
        mem_req_ready = 1'b1;
        a  = mem_req_addr;
        w  = mem_req_write;
        wd = mem_req_wdata;
        @(negedge clk);
        mem_req_ready = 1'b0;
        if (w) begin
          mem[a] = wd;
          n_wr++;
          wr_addr = a;
          wr_data = wd;
        end else begin
          n_rd++;
          rd_addr = a;
        end
        repeat ($urandom % 4) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_rdata = w ? 32'h0 : rd_mem(a);
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end
    end
  end

  task automatic do_walk(input logic [19:0] vpn, input logic st, input int nmid,
                         input logic [31:0] b1, input logic [31:0] b2);
    logic [31:0] addr, old_e, new_e;
    logic        seen_fill, seen_fault, busy_ok, f_ok;
    int          cyc;
    addr  = cur_base + {10'd0, vpn, 2'b00};
    old_e = rd_mem(addr);
    new_e = exp_update(old_e, st);
    n_rd = 0; n_wr = 0;
    seen_fill = 0; seen_fault = 0; busy_ok = 1; f_ok = 1;
    @(negedge clk);
    chk(miss_ready === 1'b1 && busy === 1'b0, "R8", "idle ready before miss",
        {30'd0, miss_ready, busy}, 32'h2);
    miss_valid = 1'b1; miss_vpn = vpn; miss_write = st;
    @(negedge clk);
    miss_valid = 1'b0;
    cyc = 0;
    while (!seen_fill && !seen_fault && cyc < 2000) begin
      base_wr_en   = (cyc == 0 && nmid >= 1) || (cyc == 1 && nmid >= 2);
      base_wr_data = (cyc == 0) ? b1 : b2;
      if (busy !== 1'b1 || miss_ready !== 1'b0) busy_ok = 0;
      if (fill_valid === 1'b1) begin
        seen_fill = 1;
        if (fill_vpn !== vpn || fill_frame !== old_e[19:0] || fill_prot !== old_e[21:20]
            || fill_dirty !== new_e[24] || fault_valid !== 1'b0) f_ok = 0;
        chk(f_ok, "R7", "fill fields frame/prot/dirty",
            {fill_prot, fill_dirty, 9'd0, fill_frame}, {old_e[21:20], new_e[24], 9'd0, old_e[19:0]});
      end
      if (fault_valid === 1'b1) begin
        seen_fault = 1;
        chk(fault_vpn === vpn && fill_valid === 1'b0, "R4", "fault vpn",
            {12'd0, fault_vpn}, {12'd0, vpn});
      end
      @(negedge clk);
      cyc++;
    end
    base_wr_en = 1'b0;
    chk(cyc < 2000, "R8", "walk completes", cyc, 0);
    chk(busy_ok, "R8", "busy held through walk", {31'd0, busy_ok}, 32'd1);
    chk(busy === 1'b0 && miss_ready === 1'b1 && fill_valid === 1'b0 && fault_valid === 1'b0,
        "R8", "idle after walk", {29'd0, busy, fill_valid, fault_valid}, 32'd0);
    chk(n_rd == 1 && rd_addr === addr, "R2", "entry read address", rd_addr, addr);
    if (!old_e[22]) begin
      chk(seen_fault && !seen_fill, "R4", "invalid entry faults", {31'd0, seen_fault}, 32'd1);
      chk(n_wr == 0 && rd_mem(addr) === old_e, "R4", "no write-back on fault", n_wr, 0);
    end else begin
      chk(seen_fill && !seen_fault, "R7", "valid entry fills", {31'd0, seen_fill}, 32'd1);
      if (new_e != old_e) begin
        chk(n_wr == 1 && wr_addr === addr && wr_data === new_e, "R5", "write-back word",
            wr_data, new_e);
      end else begin
        chk(n_wr == 0, "R6", "no write-back when bits already set", n_wr, 0);
      end
    end
    if (nmid >= 2) cur_base = b2;
    else if (nmid == 1) cur_base = b1;
  endtask

  task automatic set_base(input logic [31:0] b);
    @(negedge clk);
    base_wr_en = 1'b1; base_wr_data = b;
    @(negedge clk);
    base_wr_en = 1'b0;
    cur_base = b;
  endtask

  initial begin
    int wd;
    wd = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] r;
    r = $urandom(32'd7717);
    for (int v = 0; v < 64; v++) begin
      mem[BASE_A + v * 4] = mk_entry(($urandom % 5) != 0);
      mem[BASE_B + v * 4] = mk_entry(($urandom % 5) != 0);
      mem[BASE_C + v * 4] = mk_entry(1'b1);
    end
    mem[BASE_A + 32'h10] = 32'h0040_1234;   // vpn 4: valid, R=0, M=0
    mem[BASE_A + 32'h14] = 32'h0000_5678;   // vpn 5: invalid
    mem[BASE_A + 32'h3F_FFFC] = 32'h0079_ABCD; // top vpn: valid, prot 3
    mem[BASE_B + 32'h10] = 32'h0040_0B0B;
    mem[BASE_C + 32'h10] = 32'h0040_0C0C;

    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && miss_ready === 1'b1 && mem_req_valid === 1'b0 &&
        fill_valid === 1'b0 && fault_valid === 1'b0, "R1", "state during reset",
        {27'd0, busy, miss_ready, mem_req_valid, fill_valid, fault_valid}, 32'h8);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy === 1'b0 && miss_ready === 1'b1 && mem_req_valid === 1'b0,
        "R1", "state after reset", {29'd0, busy, miss_ready, mem_req_valid}, 32'h2);

    set_base(BASE_A);                       // R9 idle write
    do_walk(20'd4, 1'b0, 0, 0, 0);          // R5 referenced set, written back
    do_walk(20'd4, 1'b0, 0, 0, 0);          // R6 no change, no write
    do_walk(20'd4, 1'b1, 0, 0, 0);          // R5 modified set on store
    do_walk(20'd4, 1'b1, 0, 0, 0);          // R6 both set
    do_walk(20'd5, 1'b1, 0, 0, 0);          // R4 fault
    do_walk(20'hFFFFF, 1'b0, 0, 0, 0);      // R2 top page number

    // R9: base write during a walk is deferred
    do_walk(20'd4, 1'b0, 1, BASE_B, 0);
    chk(cur_base === BASE_B, "R9", "bench base tracking", cur_base, BASE_B);
    do_walk(20'd4, 1'b0, 0, 0, 0);          // must read from BASE_B
    // R9: two writes in one walk, last wins
    do_walk(20'd4, 1'b1, 2, BASE_A, BASE_C);
    do_walk(20'd4, 1'b0, 0, 0, 0);          // must read from BASE_C

    set_base(BASE_A);
    for (int i = 0; i < 150; i++) begin
      int sel;
      sel = $urandom % 10;
      if (sel == 0) begin
        do_walk(20'd64 + 20'($urandom % 16), 1'($urandom), 0, 0, 0);
      end else if (sel == 1) begin
        do_walk(20'($urandom % 64), 1'($urandom), 1, ($urandom % 2) ? BASE_A : BASE_B, 0);
      end else begin
        do_walk(20'($urandom % 64), 1'($urandom), 0, 0, 0);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule